// File: doc/BRIEF.md
# Line-Scan Pixel Output Sequencer

This block streams one finished sensor line to the parallel video output. It produces one pixel per rising clock edge, with a line-valid flag and a data-valid flag. A pulse on `line_ready` means a line has been fully acquired into the line buffer. The block then reads that buffer in ascending address order and presents each entry on `pix`, raising `lval` and `dval` together for the whole line.

Each line has a fixed length of `LINE_PIXELS` (8160 by default). A depth select chooses between full 10-bit pixels and 8-bit pixels. In 8-bit mode each pixel is truncated by dropping its two least significant bits. If a line-ready pulse arrives while a line is still being sent, it is remembered. That line starts after a short idle gap, so two lines never run into each other.

Top module: `lscan_pixel_seq`

## Requirements
- R1: While and after reset, with no line requested, `lval` and `dval` are low and `pix` is zero.
- R2: A `line_ready` pulse sampled high at a clock edge while the block is idle makes `lval` rise at the next edge. `lval` then stays high for exactly `LINE_PIXELS` consecutive cycles and falls on the edge after the last pixel.
- R3: `dval` equals `lval` on every cycle.
- R4: The k-th valid cycle of a line carries line buffer entry k-1. `rd_addr` is driven with `rd_en` high, and the entry is expected on `rd_data` one edge later.
- R5: With 10-bit depth (`depth8` = 0 at line start), `pix` equals the buffer entry unchanged.
- R6: With 8-bit depth (`depth8` = 1 at line start), `pix[7:0]` is entry bits 9..2 and `pix[9:8]` is zero. This is truncation, with no rounding.
- R7: `depth8` is sampled only on the edge that accepts a line. Changes at any other time have no effect on the line being sent.
- R8: Whenever `lval` is low, `pix` is zero.
- R9: A `line_ready` pulse that arrives during a line is held, and that line is sent next, with `lval` low for exactly two cycles between the lines. Further pulses that arrive while one request is already held merge into that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_ready | input | 1 | Pulse: a line has been acquired and may be sent |
| depth8 | input | 1 | 1 selects 8-bit output, 0 selects 10-bit |
| rd_en | output | 1 | Line buffer read strobe |
| rd_addr | output | ADDR_W | Line buffer read address (pixel index from 0) |
| rd_data | input | PIX_W | Line buffer read data, one cycle after the address |
| pix | output | PIX_W | Pixel bus |
| lval | output | 1 | Line valid |
| dval | output | 1 | Data valid |

## Verification
The assertions assume that the line buffer has a read latency of exactly one cycle. They also assume that `line_ready` is a synchronous level sampled only at rising edges. The bench meets both assumptions: its behavioural buffer model registers a computed pattern of `rd_addr` on every edge, and it changes `line_ready` and `depth8` only on falling edges. The stimulus also covers the cases these assumptions do not rule out: `depth8` toggled in the middle of a line, pulses held for several cycles, and two pulses during one line.

// File: rtl/lscan_pixel_seq.sv
module lscan_pixel_seq #(
  parameter int PIX_W       = 10,
  parameter int DROP_BITS   = 2,
  parameter int LINE_PIXELS = 8160,
  parameter int ADDR_W      = $clog2(LINE_PIXELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_ready,
  input  logic              depth8,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic [PIX_W-1:0]  pix,
  output logic              lval,
  output logic              dval
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(LINE_PIXELS - 1);

  logic              fetch, shown, pend, dsel;
  logic [ADDR_W-1:0] addr;

  wire req   = pend | line_ready;
  wire start = req & ~fetch & ~shown;
  wire last  = fetch & (addr == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch <= 1'b0;
      shown <= 1'b0;
      pend  <= 1'b0;
      dsel  <= 1'b0;
      addr  <= '0;
    end else begin
      pend  <= req & ~start;
      shown <= fetch;
      if (start) begin
        fetch <= 1'b1;
        addr  <= '0;
        dsel  <= depth8;
      end else if (fetch) begin
        if (last) fetch <= 1'b0;
        else      addr  <= addr + 1'b1;
      end
    end
  end

  assign rd_en   = fetch;
  assign rd_addr = addr;
  assign lval    = shown;
  assign dval    = shown;
  assign pix     = !shown ? '0 : (dsel ? (rd_data >> DROP_BITS) : rd_data);
endmodule

// File: rtl/lscan_pixel_seq_chk.sv
module lscan_pixel_seq_chk #(
  parameter int PIX_W       = 10,
  parameter int DROP_BITS   = 2,
  parameter int LINE_PIXELS = 8160
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lval,
  input logic             dval,
  input logic [PIX_W-1:0] pix,
  input logic             dsel
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= 0;
    else if (lval) run <= run + 1;
    else           run <= 0;
  end

  // R3
  flags_match_chk: assert property (@(posedge clk) disable iff (!rst_n) lval == dval);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !lval |-> pix == '0);

  // R2
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) lval |-> run < LINE_PIXELS);

  // R2
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(lval) |-> run == LINE_PIXELS);

  // R6
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && dsel) |-> (pix >> (PIX_W - DROP_BITS)) == '0);

  // R7
  depth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && $past(lval)) |-> $stable(dsel));

  // R9
  line_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(lval) |=> !lval);
endmodule

bind lscan_pixel_seq lscan_pixel_seq_chk #(
  .PIX_W(PIX_W), .DROP_BITS(DROP_BITS), .LINE_PIXELS(LINE_PIXELS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lval(lval), .dval(dval), .pix(pix), .dsel(dsel)
);

// File: tb/tb_lscan_pixel_seq.sv
module tb_lscan_pixel_seq;
  localparam int N  = 8160;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0, line_ready = 0, depth8 = 0;
  logic rd_en, lval, dval;
  logic [AW-1:0] rd_addr;
  logic [9:0] rd_data, pix;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lscan_pixel_seq dut (
    .clk(clk), .rst_n(rst_n), .line_ready(line_ready), .depth8(depth8),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pix(pix), .lval(lval), .dval(dval)
  );

  function automatic logic [9:0] pat(int i);
    return 10'((i * 389 + 77) ^ (i >> 3));
  endfunction

  always @(posedge clk) rd_data <= pat(int'(rd_addr));

  // reference model: output-level timeline
  bit m_pend, m_start, m_lv, m_d8, m_d8_next;
  int m_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_start = 0; m_lv = 0; m_d8 = 0; m_idx = 0;
    end else begin
      bit acc;
      acc = !m_lv && !m_start && (m_pend || line_ready);
      m_pend = (m_pend || line_ready) && !acc;
      if (m_start) begin
        m_lv = 1; m_idx = 0; m_d8 = m_d8_next;
      end else if (m_lv) begin
        if (m_idx == N - 1) m_lv = 0;
        else m_idx++;
      end
      if (acc) m_d8_next = depth8;
      m_start = acc;
    end
  end

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int run = 0, gap = 0, last_gap = 0, lines = 0;
  always @(negedge clk) if (rst_n) begin
    logic [9:0] e;
    e = !m_lv ? 10'd0 : (m_d8 ? {2'b00, pat(m_idx) >> 2} : pat(m_idx));
    check("R2 lval", {9'd0, lval}, {9'd0, m_lv});
    check("R3 dval", {9'd0, dval}, {9'd0, lval});
    check(!m_lv ? "R8 pix" : (m_d8 ? "R6 pix" : "R4/R5 pix"), pix, e);
    if (lval) begin
      if (run == 0) last_gap = gap;
      run++; gap = 0;
    end else begin
      if (run > 0) begin
        check("R2 line length", 10'(run == N), 10'd1);
        lines++;
      end
      run = 0; gap++;
    end
  end

  task automatic pulse(int len);
    @(negedge clk) line_ready = 1;
    repeat (len) @(negedge clk);
    line_ready = 0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int l0;
    repeat (3) @(negedge clk);
    check("R1 reset lval", {9'd0, lval}, 10'd0);
    check("R1 reset pix", pix, 10'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 idle dval", {9'd0, dval}, 10'd0);

    // R5: 10-bit line
    depth8 = 0; pulse(1);
    repeat (N + 20) @(negedge clk);

    // R6 and R7: 8-bit line, select flipped mid-line
    depth8 = 1; pulse(1); depth8 = 0;
    repeat (300) @(negedge clk);
    depth8 = 1;
    repeat (N) @(negedge clk);
    depth8 = 0;
    check("R6 line done", 10'(lines), 10'd2);

    // R9: two pulses during a line merge into one queued line
    l0 = lines;
    pulse(1);
    repeat (1000) @(negedge clk);
    pulse(1);
    repeat (1000) @(negedge clk);
    depth8 = 1; pulse(1);
    repeat (2 * N + 50) @(negedge clk);
    check("R9 merged lines", 10'(lines - l0), 10'd2);
    check("R9 gap", 10'(last_gap), 10'd2);

    // R7: depth toggles while idle have no effect; held pulse of 3 cycles
    depth8 = 0;
    repeat (5) @(negedge clk);
    depth8 = 1;
    repeat (5) @(negedge clk);
    check("R8 idle pix", pix, 10'd0);
    l0 = lines;
    pulse(3);
    depth8 = 0;
    repeat (2 * N + 50) @(negedge clk);
    check("R9 held pulse lines", 10'(lines - l0), 10'd2);
    finish_run();
  end
endmodule